// File: doc/BRIEF.md
# Calendar Clock Counter with Alarm

This block keeps the time of day and the calendar date for a system that supplies a one-second tick. Each accepted tick opens a short update-pending window, with the `uip` output high, for a fixed number of clock cycles. At the end of that window every field advances together. The clock fields are seconds, minutes and hours. The calendar fields are day of week, day of month, month and a two-digit year. Carries ripple through all fields in the same cycle.

One mode input selects BCD or plain binary coding for all fields. A second mode input selects 24-hour or 12-hour hours. In 12-hour mode, bit 7 of the hours field is the afternoon marker. February takes 29 days whenever the two-digit year is a multiple of four.

A host raises `hold` to freeze the counters and write any field, or any of the three alarm fields, through a single load port. When each update completes, the block pulses `upd_flag`. If the new time matches the alarm, it also pulses `alm_flag`.

Top module: `cal_clock`

## Requirements
- R1: After reset: seconds, minutes and hours are 0, day of week is 1, date is 1, month is 1 and year is 0. `uip`, `upd_flag` and `alm_flag` are low. All three alarm fields are 0.
- R2: A `tick` sampled high while `hold` is low and no window is open raises `uip` for exactly UIP_CYC cycles. On the edge that ends the window, the fields take their next values and `upd_flag` is high for exactly one cycle.
- R3: In BCD mode (`bin_mode`=0), seconds and minutes count 0x00 to 0x59. Going past 0x59 returns the field to 0x00 and carries into the next field.
- R4: In binary mode (`bin_mode`=1), every field uses plain binary values. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0.
- R5: In 24-hour mode (`h24`=1), hours count 0 to 23. Going past 23 returns hours to 0 and advances the day.
- R6: In 12-hour mode (`h24`=0), hours count 1 to 12 and bit 7 set means PM (12 PM is 0x92 in BCD, 12 AM is 0x12). 11 AM goes to 12 PM, 12 goes to 1 with the same marker, and 11 PM goes to 12 AM and advances the day.
- R7: Day of week counts 1 to 7 and wraps from 7 to 1 when the day advances.
- R8: The last date is 31 for months 1, 3, 5, 7, 8, 10 and 12 and 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the year is divisible by 4, and 28 otherwise. Past the last date, the date becomes 1 and the month advances.
- R9: Past month 12, the month becomes 1 and the year advances. Year 99 wraps to 0.
- R10: While `hold` is high, ticks are ignored, `uip` stays low and no field changes except through a load. A load (`ld_en`=1) writes `ld_data` into the field chosen by `ld_sel`, and only while `hold` is high. The `ld_sel` codes are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours. A load with `hold` low has no effect.
- R11: `alm_flag` pulses in the same cycle as `upd_flag` when the updated seconds, minutes and hours each equal their alarm field. An alarm field whose bits 7 and 6 are both 1 matches any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second pulse |
| hold | input | 1 | Inhibits updates and enables loads |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24 | input | 1 | 1 = 24-hour mode, 0 = 12-hour mode |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 4 | Field select for loads |
| ld_data | input | 8 | Load value |
| sec | output | 8 | Seconds |
| min | output | 8 | Minutes |
| hr | output | 8 | Hours, bit 7 = PM in 12-hour mode |
| dow | output | 8 | Day of week |
| date | output | 8 | Day of month |
| mon | output | 8 | Month |
| yr | output | 8 | Year |
| uip | output | 1 | Update window open |
| upd_flag | output | 1 | Update done pulse |
| alm_flag | output | 1 | Alarm match pulse |

## Verification
The visible fields are the counter state itself. A wrong rollover limit or a missed carry therefore appears at the outputs on the very update where it happens, UIP_CYC+1 cycles after the tick. Faults in the window counter show up as a `uip` pulse of the wrong length, or as `upd_flag` arriving early or late. Faults in month length or leap-year handling stay hidden until a tick at 23:59:59 on a final date, so the directed cases load exactly those instants. An alarm-compare fault affects only `alm_flag`, and only on the update that lands on the alarm time.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW   = 8;
  localparam int SELW = 4;

  typedef logic [FW-1:0] fld_t;

  typedef enum logic [SELW-1:0] {
    SEL_SEC  = 4'd0,
    SEL_MIN  = 4'd1,
    SEL_HR   = 4'd2,
    SEL_DOW  = 4'd3,
    SEL_DATE = 4'd4,
    SEL_MON  = 4'd5,
    SEL_YR   = 4'd6,
    SEL_ASEC = 4'd7,
    SEL_AMIN = 4'd8,
    SEL_AHR  = 4'd9
  } sel_e;

  // constant 0..99 rendered in the active field coding
  function automatic fld_t fmt(input int unsigned n, input logic bin);
    fld_t r;
    if (bin) r = fld_t'(n);
    else     r = fld_t'(((n / 10) << 4) | (n % 10));
    return r;
  endfunction

  // field value as plain binary
  function automatic fld_t to_bin(input fld_t v, input logic bin);
    fld_t r;
    if (bin) r = v;
    else     r = ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    return r;
  endfunction

  // plus one in the active coding
  function automatic fld_t inc(input fld_t v, input logic bin);
    fld_t r;
    if (bin)                r = v + 8'd1;
    else if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                    r = v + 8'd1;
    return r;
  endfunction
endpackage

// File: rtl/cal_tick_seq.sv
module cal_tick_seq #(
  parameter int UIP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  output logic uip,
  output logic fire
);
  localparam int CW = $clog2(UIP_CYC + 1);
  localparam logic [CW-1:0] START = CW'(UIP_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      if (hold) cnt <= '0;
      else      cnt <= cnt - 1'b1;
    end else if (tick && !hold) begin
      cnt <= START;
    end
  end

  assign uip  = (cnt != '0);
  assign fire = (cnt == CW'(1)) && !hold;

  AST_UIP_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(uip) |-> $past(tick)); // R2
  AST_UIP_HOLD_CLOSE: assert property (@(posedge clk) disable iff (rst)
    hold |=> !uip); // R10
endmodule

// File: rtl/cal_next.sv
module cal_next
  import cal_pkg::*;
(
  input  logic bin,
  input  logic h24,
  input  fld_t sec_i,
  input  fld_t min_i,
  input  fld_t hr_i,
  input  fld_t dow_i,
  input  fld_t date_i,
  input  fld_t mon_i,
  input  fld_t yr_i,
  output fld_t sec_o,
  output fld_t min_o,
  output fld_t hr_o,
  output fld_t dow_o,
  output fld_t date_o,
  output fld_t mon_o,
  output fld_t yr_o
);
  logic c_min, c_hr, c_day, c_mon, c_yr;
  fld_t mon_b, yr_b, last_day, hv;
  logic leap, pm;

  always_comb begin
    // seconds / minutes
    c_min = (sec_i == fmt(59, bin));
    sec_o = c_min ? '0 : inc(sec_i, bin);
    c_hr  = c_min && (min_i == fmt(59, bin));
    min_o = c_min ? (c_hr ? '0 : inc(min_i, bin)) : min_i;

    // hours
    hv    = {1'b0, hr_i[6:0]};
    pm    = hr_i[7];
    hr_o  = hr_i;
    c_day = 1'b0;
    if (c_hr) begin
      if (h24) begin
        if (hr_i == fmt(23, bin)) begin
          hr_o  = '0;
          c_day = 1'b1;
        end else begin
          hr_o = inc(hr_i, bin);
        end
      end else begin
        if (hv == fmt(12, bin)) begin
          hr_o = {pm, fmt(1, bin)[6:0]};
        end else if (hv == fmt(11, bin)) begin
          hr_o  = {~pm, fmt(12, bin)[6:0]};
          c_day = pm;
        end else begin
          hr_o = {pm, inc(hv, bin)[6:0]};
        end
      end
    end

    // day of week: 1..7 codes identical in both codings
    dow_o = c_day ? ((dow_i == 8'd7) ? 8'd1 : dow_i + 8'd1) : dow_i;

    // month length
    mon_b = to_bin(mon_i, bin);
    yr_b  = to_bin(yr_i, bin);
    leap  = (yr_b[1:0] == 2'b00);
    case (mon_b)
      8'd2:                      last_day = leap ? fmt(29, bin) : fmt(28, bin);
      8'd4, 8'd6, 8'd9, 8'd11:   last_day = fmt(30, bin);
      default:                   last_day = fmt(31, bin);
    endcase

    c_mon  = c_day && (date_i == last_day);
    date_o = c_day ? (c_mon ? 8'd1 : inc(date_i, bin)) : date_i;
    c_yr   = c_mon && (mon_i == fmt(12, bin));
    mon_o  = c_mon ? (c_yr ? 8'd1 : inc(mon_i, bin)) : mon_i;
    yr_o   = c_yr ? ((yr_i == fmt(99, bin)) ? '0 : inc(yr_i, bin)) : yr_i;
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_pkg::*;
#(
  parameter int NF = 3
) (
  input  fld_t [NF-1:0] cur,
  input  fld_t [NF-1:0] alm,
  output logic          match
);
  logic [NF-1:0] hit;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign hit[i] = (alm[i][7:6] == 2'b11) || (alm[i] == cur[i]);
  end

  assign match = &hit;
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int UIP_CYC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            hold,
  input  logic            bin_mode,
  input  logic            h24,
  input  logic            ld_en,
  input  logic [SELW-1:0] ld_sel,
  input  logic [FW-1:0]   ld_data,
  output logic [FW-1:0]   sec,
  output logic [FW-1:0]   min,
  output logic [FW-1:0]   hr,
  output logic [FW-1:0]   dow,
  output logic [FW-1:0]   date,
  output logic [FW-1:0]   mon,
  output logic [FW-1:0]   yr,
  output logic            uip,
  output logic            upd_flag,
  output logic            alm_flag
);
  localparam int NALM = 3;

  fld_t sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q;
  fld_t sec_n, min_n, hr_n, dow_n, date_n, mon_n, yr_n;
  fld_t [NALM-1:0] alm_q;
  fld_t [NALM-1:0] cur_n;
  logic fire, match, upd_q, alm_fq;

  cal_tick_seq #(.UIP_CYC(UIP_CYC)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .hold(hold), .uip(uip), .fire(fire)
  );

  cal_next u_next (
    .bin(bin_mode), .h24(h24),
    .sec_i(sec_q), .min_i(min_q), .hr_i(hr_q), .dow_i(dow_q),
    .date_i(date_q), .mon_i(mon_q), .yr_i(yr_q),
    .sec_o(sec_n), .min_o(min_n), .hr_o(hr_n), .dow_o(dow_n),
    .date_o(date_n), .mon_o(mon_n), .yr_o(yr_n)
  );

  assign cur_n = {hr_n, min_n, sec_n};

  cal_alarm_cmp #(.NF(NALM)) u_alm (
    .cur(cur_n), .alm(alm_q), .match(match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      min_q  <= '0;
      hr_q   <= '0;
      dow_q  <= 8'd1;
      date_q <= 8'd1;
      mon_q  <= 8'd1;
      yr_q   <= '0;
      alm_q  <= '0;
      upd_q  <= 1'b0;
      alm_fq <= 1'b0;
    end else begin
      upd_q  <= fire;
      alm_fq <= fire && match;
      if (fire) begin
        sec_q  <= sec_n;
        min_q  <= min_n;
        hr_q   <= hr_n;
        dow_q  <= dow_n;
        date_q <= date_n;
        mon_q  <= mon_n;
        yr_q   <= yr_n;
      end else if (hold && ld_en) begin
        case (sel_e'(ld_sel))
          SEL_SEC:  sec_q    <= ld_data;
          SEL_MIN:  min_q    <= ld_data;
          SEL_HR:   hr_q     <= ld_data;
          SEL_DOW:  dow_q    <= ld_data;
          SEL_DATE: date_q   <= ld_data;
          SEL_MON:  mon_q    <= ld_data;
          SEL_YR:   yr_q     <= ld_data;
          SEL_ASEC: alm_q[0] <= ld_data;
          SEL_AMIN: alm_q[1] <= ld_data;
          SEL_AHR:  alm_q[2] <= ld_data;
          default: ;
        endcase
      end
    end
  end

  assign sec      = sec_q;
  assign min      = min_q;
  assign hr       = hr_q;
  assign dow      = dow_q;
  assign date     = date_q;
  assign mon      = mon_q;
  assign yr       = yr_q;
  assign upd_flag = upd_q;
  assign alm_flag = alm_fq;

  AST_UPD_AFTER_UIP: assert property (@(posedge clk) disable iff (rst)
    upd_flag |-> $past(uip)); // R2
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    upd_flag |=> !upd_flag); // R2
  AST_NO_UPD_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold |=> !upd_flag); // R10
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (hold && !ld_en) |=> ($stable(sec) && $stable(min) && $stable(hr) && $stable(date))); // R10
  AST_ALM_WITH_UPD: assert property (@(posedge clk) disable iff (rst)
    alm_flag |-> upd_flag); // R11
endmodule

// File: tb/sim_cal_clock.sv
module sim_cal_clock;
  localparam int UIP_CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, hold = 1'b0, bin_mode = 1'b0, h24 = 1'b1, ld_en = 1'b0;
  logic [3:0] ld_sel = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] sec, min, hr, dow, date, mon, yr;
  logic uip, upd_flag, alm_flag;
  int checks = 0;
  int errors = 0;
  logic last_alm;

  always #2 clk = ~clk;

  cal_clock #(.UIP_CYC(UIP_CYC)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .hold(hold), .bin_mode(bin_mode), .h24(h24),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .sec(sec), .min(min), .hr(hr), .dow(dow), .date(date), .mon(mon), .yr(yr),
    .uip(uip), .upd_flag(upd_flag), .alm_flag(alm_flag)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic ld(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); ld_sel = s; ld_data = d; ld_en = 1'b1;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, m, s, dw, dt, mo, y);
    @(negedge clk); hold = 1'b1;
    ld(4'd0, s); ld(4'd1, m); ld(4'd2, h); ld(4'd3, dw);
    ld(4'd4, dt); ld(4'd5, mo); ld(4'd6, y);
    @(negedge clk); hold = 1'b0;
  endtask

  task automatic set_alarm(input logic [7:0] h, m, s);
    @(negedge clk); hold = 1'b1;
    ld(4'd7, s); ld(4'd8, m); ld(4'd9, h);
    @(negedge clk); hold = 1'b0;
  endtask

  // tick, check window timing (R2), record alarm flag
  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R2", "uip open", {7'd0, uip}, 8'd1);
    chk("R2", "no early upd", {7'd0, upd_flag}, 8'd0);
    repeat (UIP_CYC - 1) @(negedge clk);
    chk("R2", "uip last", {7'd0, uip}, 8'd1);
    @(negedge clk);
    chk("R2", "upd pulse", {7'd0, upd_flag}, 8'd1);
    chk("R2", "uip closed", {7'd0, uip}, 8'd0);
    last_alm = alm_flag;
    @(negedge clk);
    chk("R2", "upd single", {7'd0, upd_flag}, 8'd0);
  endtask

  task automatic t_reset();
    chk("R1", "sec", sec, 8'h00); chk("R1", "min", min, 8'h00);
    chk("R1", "hr", hr, 8'h00);   chk("R1", "dow", dow, 8'h01);
    chk("R1", "date", date, 8'h01); chk("R1", "mon", mon, 8'h01);
    chk("R1", "yr", yr, 8'h00);
    chk("R1", "flags", {5'd0, uip, upd_flag, alm_flag}, 8'h00);
  endtask

  task automatic t_bcd_rollover();
    bin_mode = 1'b0; h24 = 1'b1;
    set_all(8'h23, 8'h59, 8'h58, 8'h07, 8'h31, 8'h12, 8'h99);
    do_tick();
    chk("R3", "sec 58->59", sec, 8'h59);
    chk("R3", "min hold", min, 8'h59);
    do_tick();
    chk("R3", "sec wrap", sec, 8'h00);
    chk("R3", "min wrap", min, 8'h00);
    chk("R5", "hr 23->0", hr, 8'h00);
    chk("R7", "dow 7->1", dow, 8'h01);
    chk("R9", "date", date, 8'h01);
    chk("R9", "mon 12->1", mon, 8'h01);
    chk("R9", "yr 99->0", yr, 8'h00);
  endtask

  task automatic t_binary();
    bin_mode = 1'b1; h24 = 1'b1;
    set_all(8'd22, 8'd59, 8'd59, 8'd3, 8'd15, 8'd6, 8'd30);
    do_tick();
    chk("R4", "bin sec", sec, 8'd0);
    chk("R4", "bin min", min, 8'd0);
    chk("R4", "bin hr", hr, 8'd23);
    chk("R4", "bin date unchanged", date, 8'd15);
    set_all(8'd23, 8'd59, 8'd59, 8'd3, 8'd30, 8'd6, 8'd30);
    do_tick();
    chk("R4", "bin hr wrap", hr, 8'd0);
    chk("R8", "bin jun 30 date", date, 8'd1);
    chk("R8", "bin jun 30 mon", mon, 8'd7);
    chk("R7", "bin dow", dow, 8'd4);
    bin_mode = 1'b0;
  endtask

  task automatic t_month_len();
    bin_mode = 1'b0; h24 = 1'b1;
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
    do_tick();
    chk("R8", "feb28 nonleap date", date, 8'h01);
    chk("R8", "feb28 nonleap mon", mon, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
    do_tick();
    chk("R8", "feb28 leap date", date, 8'h29);
    chk("R8", "feb28 leap mon", mon, 8'h02);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h24);
    do_tick();
    chk("R8", "feb29 leap date", date, 8'h01);
    chk("R8", "feb29 leap mon", mon, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h24);
    do_tick();
    chk("R8", "apr30 date", date, 8'h01);
    chk("R8", "apr30 mon", mon, 8'h05);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h01, 8'h24);
    do_tick();
    chk("R8", "jan30 date", date, 8'h31);
    chk("R8", "jan30 mon", mon, 8'h01);
  endtask

  task automatic t_12h();
    bin_mode = 1'b0; h24 = 1'b0;
    set_all(8'h11, 8'h59, 8'h59, 8'h02, 8'h05, 8'h01, 8'h00);
    do_tick();
    chk("R6", "11AM->12PM", hr, 8'h92);
    chk("R6", "no day step", date, 8'h05);
    set_all(8'h92, 8'h59, 8'h59, 8'h02, 8'h05, 8'h01, 8'h00);
    do_tick();
    chk("R6", "12PM->1PM", hr, 8'h81);
    set_all(8'h12, 8'h59, 8'h59, 8'h02, 8'h05, 8'h01, 8'h00);
    do_tick();
    chk("R6", "12AM->1AM", hr, 8'h01);
    set_all(8'h91, 8'h59, 8'h59, 8'h02, 8'h05, 8'h01, 8'h00);
    do_tick();
    chk("R6", "11PM->12AM", hr, 8'h12);
    chk("R6", "day step date", date, 8'h06);
    chk("R6", "day step dow", dow, 8'h03);
    h24 = 1'b1;
  endtask

  task automatic t_hold();
    bool_dummy();
    set_all(8'h10, 8'h20, 8'h30, 8'h04, 8'h15, 8'h06, 8'h40);
    @(negedge clk); hold = 1'b1; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < UIP_CYC + 3; i++) begin
        if (uip || upd_flag) seen = 1'b1;
        @(negedge clk);
      end
      chk("R10", "tick ignored in hold", {7'd0, seen}, 8'd0);
    end
    chk("R10", "sec frozen", sec, 8'h30);
    hold = 1'b0;
    @(negedge clk); ld_sel = 4'd0; ld_data = 8'h33; ld_en = 1'b1;
    @(negedge clk); ld_en = 1'b0; ld_sel = 4'd4; ld_data = 8'h02; ld_en = 1'b1;
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk);
    chk("R10", "load ignored sec", sec, 8'h30);
    chk("R10", "load ignored date", date, 8'h15);
    chk("R10", "load in hold hr", hr, 8'h10);
  endtask

  task automatic bool_dummy();
    bin_mode = 1'b0; h24 = 1'b1;
  endtask

  task automatic t_alarm();
    bin_mode = 1'b0; h24 = 1'b1;
    set_alarm(8'h00, 8'h00, 8'h05);
    set_all(8'h00, 8'h00, 8'h04, 8'h01, 8'h01, 8'h01, 8'h00);
    do_tick();
    chk("R11", "exact match", {7'd0, last_alm}, 8'd1);
    do_tick();
    chk("R11", "no match next", {7'd0, last_alm}, 8'd0);
    set_alarm(8'hC3, 8'hC0, 8'h10);
    set_all(8'h12, 8'h34, 8'h09, 8'h01, 8'h01, 8'h01, 8'h00);
    do_tick();
    chk("R11", "dont care match", {7'd0, last_alm}, 8'd1);
    set_alarm(8'hC3, 8'h35, 8'h10);
    set_all(8'h12, 8'h34, 8'h09, 8'h01, 8'h01, 8'h01, 8'h00);
    do_tick();
    chk("R11", "min mismatch", {7'd0, last_alm}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bcd_rollover();
    t_binary();
    t_month_len();
    t_12h();
    t_hold();
    t_alarm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule